// File: doc/BRIEF.md
# Two-Channel DC-Blocking Filter with Offset Hold

This block sits directly behind a stereo audio converter. Both channels arrive together as two's-complement samples, marked by one valid strobe. For each channel the block keeps a running estimate of the DC offset and subtracts it, so that only the AC content is passed on.

The estimate is a leaky integrator. It is updated once per valid sample, which makes the corner frequency scale with the sample rate and not with the clock. A shift parameter sets how slowly the estimate follows the input.

Three control inputs, as they would come from a control register, change the output path:
- A hold control freezes both estimates at their current values while subtraction continues. This removes a fixed offset and keeps the response flat down to DC.
- A pass-through control sends the raw samples to the output.
- A silence control forces both outputs to zero.

Top module: `dcblk_top`

## Requirements
- R1: Samples are DATA_W-bit (default 24) two's complement. Each channel keeps an estimate E with SHIFT fractional bits, starting at 0. On a valid sample x, the filtered output is x − floor(E / 2^SHIFT). E then becomes E + floor((x·2^SHIFT − E) / 2^SHIFT).
- R2: The filtered difference is formed at extended width and then saturated. Positive overflow gives 0x7FFFFF and negative overflow gives 0x800000; the result never wraps.
- R3: While `pass_en` is high and `mute_en` is low, the output equals the input sample, DC included. The estimate keeps tracking.
- R4: While `hold_en` is high on a valid sample, the estimate does not change, and the held value is still subtracted from the sample.
- R5: When `hold_en` falls, tracking resumes from the held estimate; the estimate is not cleared.
- R6: While `mute_en` is high on a valid sample, both outputs are zero and the output valid still pulses. `mute_en` has priority over `pass_en`. The estimate keeps tracking, unless `hold_en` is also high.
- R7: `out_valid` pulses exactly one clock after `in_valid`. Both channels are produced in that same cycle.
- R8: A synchronous reset (`rst` high) clears both estimates and both outputs to zero and drops `out_valid`.
- R9: Clock cycles without `in_valid` change neither the estimates nor the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe for both channels |
| in_left | input | DATA_W | Left input sample |
| in_right | input | DATA_W | Right input sample |
| hold_en | input | 1 | Freeze the offset estimates |
| pass_en | input | 1 | Pass samples through unfiltered |
| mute_en | input | 1 | Force outputs to zero |
| out_valid | output | 1 | Output strobe, one cycle after in_valid |
| out_left | output | DATA_W | Left output sample |
| out_right | output | DATA_W | Right output sample |

## Verification
Some properties hold cycle by cycle and are checked by the assertions:
- the one-cycle valid latency;
- the estimate staying put under hold;
- the raw sample appearing under pass-through;
- zero output under silence;
- the cleared state after reset;
- the sign of a saturated result matching the sign of the wide difference.

Other behaviour needs a reference model, and only the bench scenarios can show it:
- the numeric tracking of the integrator;
- resumption from a held estimate;
- tracking that continues hidden behind pass-through or silence;
- saturation reached after the estimate has converged to a rail.

// File: rtl/dcblk_pkg.sv
package dcblk_pkg;
  typedef enum logic [1:0] {
    SEL_FILT = 2'd0,
    SEL_PASS = 2'd1,
    SEL_ZERO = 2'd2
  } out_sel_e;
endpackage

// File: rtl/dcblk_sat.sv
module dcblk_sat #(
  parameter int IN_W  = 25,
  parameter int OUT_W = 24
) (
  input  logic signed [IN_W-1:0]  wide,
  output logic signed [OUT_W-1:0] narrow
);
  localparam logic signed [OUT_W-1:0] MAXV = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic signed [OUT_W-1:0] MINV = {1'b1, {(OUT_W-1){1'b0}}};

  logic hi_ok, lo_ok;

  always_comb begin
    hi_ok = (wide <= IN_W'(MAXV));
    lo_ok = (wide >= IN_W'(MINV));
    if (!hi_ok)      narrow = MAXV;
    else if (!lo_ok) narrow = MINV;
    else             narrow = wide[OUT_W-1:0];
  end

  // R2: no wrap, the sign of the result follows the wide difference
  always_comb begin
    p_no_wrap_r2: assert (narrow[OUT_W-1] == wide[IN_W-1]);
  end
endmodule

// File: rtl/dcblk_chan.sv
module dcblk_chan
  import dcblk_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int SHIFT  = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] x,
  input  logic                     hold_en,
  input  out_sel_e                 sel,
  output logic signed [DATA_W-1:0] y
);
  localparam int EST_W = DATA_W + SHIFT;
  localparam int DIF_W = EST_W + 1;

  logic signed [EST_W-1:0]  est_q, step, est_nx;
  logic signed [DIF_W-1:0]  x_ext, dif;
  logic signed [DATA_W-1:0] est_int, sat_y, y_q;
  logic signed [DATA_W:0]   wide;

  always_comb begin
    x_ext   = {x[DATA_W-1], x, {SHIFT{1'b0}}};
    dif     = x_ext - {est_q[EST_W-1], est_q};
    step    = EST_W'(dif >>> SHIFT);
    est_nx  = est_q + step;
    est_int = est_q[EST_W-1:SHIFT];
    wide    = {x[DATA_W-1], x} - {est_int[DATA_W-1], est_int};
  end

  dcblk_sat #(.IN_W(DATA_W + 1), .OUT_W(DATA_W)) u_sat (
    .wide  (wide),
    .narrow(sat_y)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      est_q <= '0;
      y_q   <= '0;
    end else if (in_valid) begin
      if (!hold_en) est_q <= est_nx;
      case (sel)
        SEL_PASS: y_q <= x;
        SEL_ZERO: y_q <= '0;
        default:  y_q <= sat_y;
      endcase
    end
  end

  assign y = y_q;

  p_hold_est_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && hold_en) |=> (est_q == $past(est_q)));
  p_idle_keep_r9: assert property (@(posedge clk) disable iff (rst)
    (!in_valid) |=> ($stable(est_q) && $stable(y_q)));
  p_pass_raw_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && sel == SEL_PASS) |=> (y_q == $past(x)));
  p_zero_out_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && sel == SEL_ZERO) |=> (y_q == '0));
  p_reset_clear_r8: assert property (@(posedge clk)
    rst |=> (est_q == '0 && y_q == '0));
endmodule

// File: rtl/dcblk_top.sv
module dcblk_top
  import dcblk_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int SHIFT  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_left,
  input  logic [DATA_W-1:0] in_right,
  input  logic              hold_en,
  input  logic              pass_en,
  input  logic              mute_en,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_left,
  output logic [DATA_W-1:0] out_right
);
  localparam int NCH = 2;

  out_sel_e                 sel;
  logic signed [DATA_W-1:0] xin  [NCH];
  logic signed [DATA_W-1:0] yout [NCH];
  logic                     vld_q;

  always_comb begin
    if (mute_en)      sel = SEL_ZERO;
    else if (pass_en) sel = SEL_PASS;
    else              sel = SEL_FILT;
  end

  assign xin[0] = in_left;
  assign xin[1] = in_right;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dcblk_chan #(.DATA_W(DATA_W), .SHIFT(SHIFT)) u_chan (
      .clk     (clk),
      .rst     (rst),
      .in_valid(in_valid),
      .x       (xin[c]),
      .hold_en (hold_en),
      .sel     (sel),
      .y       (yout[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) vld_q <= 1'b0;
    else     vld_q <= in_valid;
  end

  assign out_valid = vld_q;
  assign out_left  = yout[0];
  assign out_right = yout[1];

  p_lat_on_r7: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_lat_off_r7: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  p_reset_valid_r8: assert property (@(posedge clk)
    rst |=> !out_valid);
endmodule

// File: tb/dcblk_top_bench.sv
module dcblk_top_bench;
  localparam int  CLK_P  = 10;
  localparam int  DW     = 24;
  localparam int  SH     = 8;
  localparam longint MAXV = 64'sd8388607;
  localparam longint MINV = -64'sd8388608;

  logic clk = 0, rst = 1, in_valid = 0, hold_en = 0, pass_en = 0, mute_en = 0;
  logic [DW-1:0] in_left = '0, in_right = '0;
  logic out_valid;
  logic [DW-1:0] out_left, out_right;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  longint est [2];
  logic [2*DW-1:0] sb_q [$];
  string tag = "R1";

  always #(CLK_P/2) clk = ~clk;

  dcblk_top #(.DATA_W(DW), .SHIFT(SH)) u_dcblk_top (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_left(in_left),
    .in_right(in_right), .hold_en(hold_en), .pass_en(pass_en),
    .mute_en(mute_en), .out_valid(out_valid), .out_left(out_left),
    .out_right(out_right));

  function automatic longint sat(longint v);
    if (v > MAXV) return MAXV;
    if (v < MINV) return MINV;
    return v;
  endfunction

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: pops expected results as the design produces them
  always @(negedge clk) begin
    if (!rst && out_valid && !done) begin
      if (sb_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R7: actual unexpected valid expected none");
      end else begin
        logic [2*DW-1:0] e;
        e = sb_q.pop_front();
        check({tag, " left"},  out_left,  e[2*DW-1:DW]);
        check({tag, " right"}, out_right, e[DW-1:0]);
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1; in_valid = 0; hold_en = 0; pass_en = 0; mute_en = 0;
    @(negedge clk);
    @(negedge clk);
    rst = 0;
    est[0] = 0; est[1] = 0;
    sb_q.delete();
    check("R8 valid", {23'd0, out_valid}, '0);
    check("R8 left", out_left, '0);
    check("R8 right", out_right, '0);
  endtask

  // driver: applies one sample, computes expected from the requirements
  task automatic send(longint l, longint r, bit hd, bit ps, bit mt);
    longint xs [2];
    longint ex [2];
    @(negedge clk);
    xs[0] = l; xs[1] = r;
    in_valid = 1; hold_en = hd; pass_en = ps; mute_en = mt;
    in_left = DW'(l); in_right = DW'(r);
    for (int c = 0; c < 2; c++) begin
      if (mt)      ex[c] = 0;
      else if (ps) ex[c] = xs[c];
      else         ex[c] = sat(xs[c] - (est[c] >>> SH));
      if (!hd) est[c] = est[c] + (((xs[c] <<< SH) - est[c]) >>> SH);
    end
    sb_q.push_back({DW'(ex[0]), DW'(ex[1])});
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 0;
    end
  endtask

  task automatic drain();
    idle(3);
    if (sb_q.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL R7: actual %0d pending expected 0", sb_q.size());
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();                                   // R8
    tag = "R1";                                   // DC steps with a ripple
    for (int i = 0; i < 300; i++)
      send(1000 + ((i % 4) * 37) - 50, -5000 + ((i % 3) * 11), 0, 0, 0);
    tag = "R9";                                   // gaps between samples
    for (int i = 0; i < 40; i++) begin
      send(200 * i, -300 * i, 0, 0, 0);
      idle(i % 3);
    end
    tag = "R4";                                   // hold and a changed input
    for (int i = 0; i < 60; i++) send(40000, -40000, 1, 0, 0);
    tag = "R5";                                   // resume from held value
    for (int i = 0; i < 60; i++) send(40000, -40000, 0, 0, 0);
    tag = "R3";                                   // raw pass, tracking continues
    for (int i = 0; i < 50; i++) send(123456, -77777, 0, 1, 0);
    for (int i = 0; i < 10; i++) send(123456, -77777, 0, 0, 0);
    tag = "R6";                                   // zero output, beats pass
    for (int i = 0; i < 30; i++) send(-654321, 98765, 0, (i % 2), 1);
    for (int i = 0; i < 10; i++) send(-654321, 98765, 0, 0, 0);
    tag = "R7";
    drain();
    do_reset();                                   // R8: estimate cleared
    tag = "R8";
    send(100, -100, 0, 0, 0);
    drain();
    tag = "R2";                                   // converge to negative rail
    for (int i = 0; i < 3000; i++) send(MINV, MAXV, 0, 0, 0);
    for (int i = 0; i < 5; i++) send(MAXV, MINV, 1, 0, 0);
    drain();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule